// File: doc/BRIEF.md
# Two-Wire Serial Clock Generator

This block produces the serial clock request for a two-wire bus master in two division stages. A 7-bit prescaler divides the system clock down to a reference tick, normally near 10 MHz: the prescale value is the system clock in MHz divided by ten, rounded. A 16-bit divider word then sets how many reference ticks the serial clock stays low and how many it stays high. The two halves are counted separately, so the waveform can be symmetric or skewed. For a symmetric clock each half count is half of (10000 / rate in kHz), rounded.

The block runs only while the enable input is high. Clearing it releases the clock line and stops the reference tick. A target device may stretch the clock by holding the line low. The block watches the sensed line level, and its high-phase count waits while the line reads low. A new divider word and fast-mode flag are picked up only where a low phase begins, so a phase that is already running is never cut short or lengthened. The fast-mode flag is an input that the controller sets whenever the configured rate is above 100 kHz. The block passes it on as a latched copy that stays consistent with the active divider.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, `scl_o` is 1 (line released), `ref_tick_o` is 0 and `fast_active_o` is 0.
- R2: While enabled, `ref_tick_o` is a one-cycle pulse repeating every P system clocks, where P is `prescale_i`. A prescale of 0 behaves as 1, which gives a tick every cycle.
- R3: The low phase of `scl_o` lasts L reference ticks, where L is `div_i[7:0]`. The high phase lasts H reference ticks, where H is `div_i[15:8]`. With no stretching, the runs are L*P and H*P system clocks long.
- R4: A half-period count of 0 in either byte behaves as a count of 1.
- R5: During the high phase, any reference tick on which `scl_sense_i` is 0 does not advance the high count. The high phase therefore ends no earlier than H ticks after the line is released, and its length stays a whole number of reference ticks.
- R6: During the low phase, `scl_sense_i` has no effect, and the low run stays exactly L*P clocks.
- R7: A change of `div_i` while enabled takes effect at the next high-to-low transition. The low phase in progress and the high phase after it keep the old counts.
- R8: `fast_active_o` copies `fast_i` at the same moments the divider is captured: continuously while disabled, and at each high-to-low transition while enabled.
- R9: With `enable_i` low, `scl_o` is 1 and `ref_tick_o` is 0 from the next clock on. After `enable_i` rises, the first cycle's edge drives `scl_o` to 0 so that operation begins with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| prescale_i | input | 7 | System clocks per reference tick (0 acts as 1) |
| div_i | input | 16 | High count in bits 15:8, low count in bits 7:0, in reference ticks |
| enable_i | input | 1 | Global enable for the clock generator |
| fast_i | input | 1 | Fast-mode flag from the configuration |
| scl_sense_i | input | 1 | Sensed level of the external clock line |
| ref_tick_o | output | 1 | One-cycle reference tick strobe |
| scl_o | output | 1 | Clock request: 0 drives low, 1 releases |
| fast_active_o | output | 1 | Fast-mode flag latched with the active divider |

## Verification
The hardest situation to reach from the ports is a divider change that lands inside a running phase. Its correct effect is visible only two phases later, and only if the bench knows exactly where the phase boundaries fall. The stimulus locks onto the serial clock by waiting for an observed falling edge. It then rewrites the divider and fast flag one cycle into that low phase and measures four consecutive runs. Stretching needs a similar alignment. The bench models the line as the request ANDed with a target hold, raises the hold on the first cycle of a high phase, and releases it a fixed number of clocks later.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int PRE_W  = 7;
  localparam int DIV_W  = 16;
  localparam int HALF_W = DIV_W / 2;

  typedef logic [PRE_W-1:0]  pre_t;
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  typedef struct packed {
    half_t hi;
    half_t lo;
  } div_fields_t;

  // Final counter index of a prescale period; zero acts as one.
  function automatic pre_t pre_last(pre_t p);
    return (p == '0) ? '0 : p - pre_t'(1);
  endfunction

  // Final counter index of a half period; zero acts as one.
  function automatic half_t half_last(half_t c);
    return (c == '0) ? '0 : c - half_t'(1);
  endfunction

  // High count lives in the upper half of the divider word.
  function automatic div_fields_t split_div(div_t d);
    div_fields_t f;
    f.hi = d[DIV_W-1:HALF_W];
    f.lo = d[HALF_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  pre_t prescale_i,
  output logic tick_o
);
  pre_t cnt_q;
  logic wrap;

  assign wrap = (cnt_q >= pre_last(prescale_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!enable_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + pre_t'(1);
      tick_o <= 1'b0;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && prescale_i >= pre_t'(2)) |=> !tick_o);

  // R9
  tick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !tick_o);
endmodule

// File: rtl/scl_div_shadow.sv
module scl_div_shadow
  import scl_gen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable_i,
  input  logic  load_i,
  input  div_t  div_i,
  input  logic  fast_i,
  output half_t hi_o,
  output half_t lo_o,
  output logic  fast_o
);
  div_fields_t fields_q;
  logic        capture;

  assign capture = !enable_i || load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      fast_o   <= 1'b0;
    end else if (capture) begin
      fields_q <= split_div(div_i);
      fast_o   <= fast_i;
    end
  end

  assign hi_o = fields_q.hi;
  assign lo_o = fields_q.lo;

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !load_i) |=> ($stable(fields_q) && $stable(fast_o)));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable_i,
  input  logic  tick_i,
  input  logic  sense_i,
  input  half_t hi_i,
  input  half_t lo_i,
  output logic  scl_o,
  output logic  low_start_o
);
  scl_phase_e phase_q, phase_d;
  half_t      cnt_q, cnt_d;
  logic       lo_done, hi_done, stretch_hold, low_advance;

  assign lo_done      = (cnt_q >= half_last(lo_i));
  assign hi_done      = (cnt_q >= half_last(hi_i));
  assign stretch_hold = enable_i && tick_i && (phase_q == PH_HIGH) && !sense_i;
  assign low_advance  = enable_i && tick_i && (phase_q == PH_LOW) && !lo_done;
  assign low_start_o  = enable_i && tick_i && (phase_q == PH_HIGH) && sense_i && hi_done;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (tick_i) begin
      if (phase_q == PH_LOW) begin
        if (lo_done) begin
          phase_d = PH_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + half_t'(1);
        end
      end else if (sense_i) begin
        if (hi_done) begin
          phase_d = PH_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + half_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      scl_o   <= 1'b1;
    end else if (!enable_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      scl_o   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      scl_o   <= (phase_d == PH_HIGH);
    end
  end

  // R5
  stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_hold |=> ($stable(cnt_q) && scl_o));

  // R6
  low_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_advance |=> (cnt_q == $past(cnt_q) + half_t'(1) && !scl_o));

  // R9
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> scl_o);

  // R3
  high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && phase_q == PH_HIGH) |-> (cnt_q <= half_last(hi_i)));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  prescale_i,
  input  logic [15:0] div_i,
  input  logic        enable_i,
  input  logic        fast_i,
  input  logic        scl_sense_i,
  output logic        ref_tick_o,
  output logic        scl_o,
  output logic        fast_active_o
);
  half_t hi_cnt, lo_cnt;
  logic  low_start;

  scl_prescaler u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .prescale_i (prescale_i),
    .tick_o     (ref_tick_o)
  );

  scl_div_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .load_i   (low_start),
    .div_i    (div_i),
    .fast_i   (fast_i),
    .hi_o     (hi_cnt),
    .lo_o     (lo_cnt),
    .fast_o   (fast_active_o)
  );

  scl_phase_gen u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .tick_i      (ref_tick_o),
    .sense_i     (scl_sense_i),
    .hi_i        (hi_cnt),
    .lo_i        (lo_cnt),
    .scl_o       (scl_o),
    .low_start_o (low_start)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (scl_o && !ref_tick_o && !fast_active_o));
endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  prescale = '0;
  logic [15:0] div = '0;
  logic        en = 1'b0;
  logic        fast = 1'b0;
  logic        hold = 1'b0;
  logic        tick, scl, fast_act;
  logic        sense;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;

  assign sense = scl & ~hold;

  always #2 clk = ~clk;

  scl_clock_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .prescale_i    (prescale),
    .div_i         (div),
    .enable_i      (en),
    .fast_i        (fast),
    .scl_sense_i   (sense),
    .ref_tick_o    (tick),
    .scl_o         (scl),
    .fast_active_o (fast_act)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic int at_least_one(int v);
    if (v < 1) return 1;
    return v;
  endfunction

  function automatic int want_low(int pre, int d);
    return at_least_one(pre) * at_least_one(d % 256);
  endfunction

  function automatic int want_high(int pre, int d);
    return at_least_one(pre) * at_least_one(d / 256);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic seek(input logic level);
    while (scl !== level) @(negedge clk);
  endtask

  task automatic run_len(input logic level, output int len);
    len = 0;
    while (scl === level) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic tick_period(output int p);
    while (tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    p = 1;
    while (tick !== 1'b1) begin
      p++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int pre, input int d, input bit f);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    prescale = pre[6:0];
    div = d[15:0];
    fast = f;
    @(negedge clk);
    check(fast_act == f, "R8", "fast copy while disabled", fast_act, f);
    en = 1'b1;
    @(negedge clk);
    check(scl == 1'b0, "R9", "low phase after enable", scl, 0);
  endtask

  task automatic measure(input int pre, input int d, input string req);
    int p, lo, hi;
    tick_period(p);
    check(p == at_least_one(pre), "R2", "tick period", p, at_least_one(pre));
    seek(1'b1);
    seek(1'b0);
    run_len(1'b0, lo);
    run_len(1'b1, hi);
    check(lo == want_low(pre, d), req, "low run", lo, want_low(pre, d));
    check(hi == want_high(pre, d), req, "high run", hi, want_high(pre, d));
  endtask

  initial begin
    int len, a, b, c, e, ticks, highs;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl == 1'b1, "R1", "scl in reset", scl, 1);
    check(tick == 1'b0, "R1", "tick in reset", tick, 0);
    check(fast_act == 1'b0, "R1", "fast in reset", fast_act, 0);
    rst_n = 1'b1;

    // R2 zero prescale acts as one; R3 basic byte split
    setup(0, 16'h0302, 1'b0);
    measure(0, 16'h0302, "R3");

    // R4 zero half counts act as one
    setup(3, 16'h0000, 1'b1);
    measure(3, 16'h0000, "R4");
    setup(2, 16'h0005, 1'b0);
    measure(2, 16'h0005, "R4");

    // R2/R3 random configurations
    for (int i = 0; i < 12; i++) begin
      int pre, d;
      bit f;
      pre = $urandom_range(0, 9);
      d = ($urandom_range(0, 6) << 8) | $urandom_range(0, 6);
      f = 1'($urandom_range(0, 1));
      setup(pre, d, f);
      measure(pre, d, "R3");
    end

    // R5 stretch: hold the line low for 10 clocks from high start
    setup(2, 16'h0403, 1'b0);
    seek(1'b0);
    seek(1'b1);
    hold = 1'b1;
    len = 0;
    while (scl === 1'b1) begin
      if (len == 10) hold = 1'b0;
      len++;
      @(negedge clk);
    end
    hold = 1'b0;
    check(len >= 16 && len <= 20, "R5", "stretched high run", len, 18);
    check(len % 2 == 0, "R5", "high run whole ticks", len % 2, 0);

    // R6 hold during low phase has no effect
    seek(1'b1);
    seek(1'b0);
    hold = 1'b1;
    len = 0;
    while (scl === 1'b0) begin
      if (len == 3) hold = 1'b0;
      len++;
      @(negedge clk);
    end
    hold = 1'b0;
    check(len == 6, "R6", "low run with hold", len, 6);

    // R7/R8 divider change inside a low phase
    setup(0, 16'h0305, 1'b0);
    seek(1'b1);
    seek(1'b0);
    div = 16'h0602;
    fast = 1'b1;
    run_len(1'b0, a);
    check(fast_act == 1'b0, "R8", "fast before boundary", fast_act, 0);
    run_len(1'b1, b);
    check(fast_act == 1'b1, "R8", "fast at low start", fast_act, 1);
    run_len(1'b0, c);
    run_len(1'b1, e);
    check(a == 5, "R7", "current low keeps old", a, 5);
    check(b == 3, "R7", "next high keeps old", b, 3);
    check(c == 2, "R7", "new low count", c, 2);
    check(e == 6, "R7", "new high count", e, 6);

    // R9 disable releases the line and stops ticks
    setup(1, 16'h0404, 1'b0);
    seek(1'b1);
    seek(1'b0);
    en = 1'b0;
    @(negedge clk);
    check(scl == 1'b1, "R9", "released after disable", scl, 1);
    check(tick == 1'b0, "R9", "no tick after disable", tick, 0);
    ticks = 0;
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      ticks += int'(tick);
      highs += int'(scl);
    end
    check(ticks == 0, "R9", "ticks while disabled", ticks, 0);
    check(highs == 10, "R9", "released while disabled", highs, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule